// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounter

This block keeps cycle accounts for an in-order pipeline. It sees one retired instruction per valid cycle and does no decoding of its own. For each instruction it receives a class code, two source register numbers with their own valid flags, a destination register that loads use, a taken flag for control transfers, a base cycle count, and a strobe that marks the last instruction of an issue group.

The block keeps a small scoreboard. A load marks its destination register as pending. When the next instruction reads that register, a fixed load-use penalty is charged once for each source operand that matches. Taken control transfers are charged a fixed redirect penalty and are counted. Untaken ones are only counted. A running total adds the base cycles and all penalties of an instruction, but only when the group strobe is high. This way a pair of parallel instructions can be entered once.

Every counter is a saturating register of parameter width. A synchronous reset clears every counter and the scoreboard. Class codes: 0 execute, 1 compare, 2 multiply-accumulate, 3 control transfer, 4 load, 5 store. Codes 6 and 7 behave as execute.

Top module: `ldsa_stall_acct`

## Requirements
- R1: While `rst` is high at a clock edge, all five counters become zero and the pending scoreboard is emptied.
- R2: When the instruction before has class 4 (load) with destination d, each valid source of the current instruction that equals d adds 2 to `ld_stall_cnt`. The two sources are checked separately, so two matching sources add 4.
- R3: A source whose valid flag is low never adds a load-use stall, whatever its register number is.
- R4: The pending mark from a load applies only to the next valid instruction, and that instruction consumes it. Cycles with `ins_vld` low neither consume the mark nor change it.
- R5: A class 3 instruction with `taken` high adds 2 to `br_stall_cnt` and 1 to `taken_cnt`.
- R6: A class 3 instruction with `taken` low adds 1 to `untaken_cnt` and leaves `br_stall_cnt` and `taken_cnt` unchanged.
- R7: A class 3 instruction checks only `src_a` for a load-use stall. `src_b` is ignored.
- R8: A class 4 instruction never adds a load-use stall. Its only effect is to set the pending mark for its destination.
- R9: When a valid instruction has `grp_last` high, `total_cnt` grows by its base cycles plus its load and branch penalties. When `grp_last` is low, `total_cnt` does not change.
- R10: Each counter stops at its all-ones value and does not wrap.
- R11: A cycle with `ins_vld` low leaves all counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_vld | input | 1 | A retired instruction is presented this cycle |
| ins_cls | input | 3 | Instruction class code |
| src_a | input | $clog2(NREG) | First source register number |
| src_a_vld | input | 1 | First source is present |
| src_b | input | $clog2(NREG) | Second source register number |
| src_b_vld | input | 1 | Second source is present |
| ld_dst | input | $clog2(NREG) | Destination register of a load |
| taken | input | 1 | Control transfer was taken |
| base_cyc | input | BASE_W | Base cycle count of the instruction |
| grp_last | input | 1 | Last instruction of its issue group |
| ld_stall_cnt | output | CNT_W | Accumulated load-use stall cycles |
| br_stall_cnt | output | CNT_W | Accumulated taken-branch penalty cycles |
| taken_cnt | output | CNT_W | Taken control transfers |
| untaken_cnt | output | CNT_W | Untaken control transfers |
| total_cnt | output | CNT_W | Accumulated total cycles |

## Verification
The bench runs load-then-consumer pairs over every destination, every class code and every source number, with every combination of valid flags. This catches a design that compares a source whose valid flag is low, that charges `src_b` on a control transfer, or that counts a doubled source only once. Directed cases cover the following: a consumer two instructions after the load, which a mask that never clears would wrongly charge; idle gaps between a load and its consumer, which a mask that clears on idle cycles would wrongly skip; and a load reading its own pending register. Long runs drive the counters into their all-ones limit, where a counter that wraps instead of saturating drops back near zero.

// File: rtl/ldsa_pkg.sv
package ldsa_pkg;
   typedef enum logic [2:0] {
      CLS_EXEC   = 3'd0,
      CLS_CMP    = 3'd1,
      CLS_MAC    = 3'd2,
      CLS_BRANCH = 3'd3,
      CLS_LOAD   = 3'd4,
      CLS_STORE  = 3'd5
   } ldsa_cls_e;

   localparam int unsigned NSRC  = 2;
   localparam int unsigned NCTR  = 5;
   localparam int unsigned C_LD  = 0;
   localparam int unsigned C_BR  = 1;
   localparam int unsigned C_TK  = 2;
   localparam int unsigned C_UT  = 3;
   localparam int unsigned C_TOT = 4;
endpackage

// File: rtl/ldsa_scoreboard.sv
module ldsa_scoreboard #(
   parameter int unsigned NREG = 16,
   parameter int unsigned NS   = 2,
   localparam int unsigned RW  = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic             set_en,
   input  logic [RW-1:0]    set_idx,
   input  logic [NS*RW-1:0] src_idx,
   input  logic [NS-1:0]    src_chk,
   output logic [NS-1:0]    hit
);
   logic [NREG-1:0] mask_q;
   logic [NREG-1:0] mask_d;

   always_comb begin
      mask_d = '0;
      if (set_en) mask_d[set_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)      mask_q <= '0;
      else if (adv) mask_q <= mask_d;
   end

   for (genvar g = 0; g < NS; g++) begin : g_src
      assign hit[g] = src_chk[g] & mask_q[src_idx[g*RW +: RW]];
   end
endmodule

// File: rtl/ldsa_satctr.sv
module ldsa_satctr #(
   parameter int unsigned W  = 32,
   parameter int unsigned IW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [IW-1:0] inc,
   output logic [W-1:0]  q
);
   logic [W:0] sum;

   assign sum = {1'b0, q} + {{(W + 1 - IW){1'b0}}, inc};

   always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (en) begin
         if (sum[W])   q <= '1;
         else          q <= sum[W-1:0];
      end
   end
endmodule

// File: rtl/ldsa_stall_acct.sv
module ldsa_stall_acct
   import ldsa_pkg::*;
#(
   parameter int unsigned NREG   = 16,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned BASE_W = 4,
   parameter int unsigned LD_PEN = 2,
   parameter int unsigned BR_PEN = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ins_vld,
   input  logic [2:0]               ins_cls,
   input  logic [$clog2(NREG)-1:0]  src_a,
   input  logic                     src_a_vld,
   input  logic [$clog2(NREG)-1:0]  src_b,
   input  logic                     src_b_vld,
   input  logic [$clog2(NREG)-1:0]  ld_dst,
   input  logic                     taken,
   input  logic [BASE_W-1:0]        base_cyc,
   input  logic                     grp_last,
   output logic [CNT_W-1:0]         ld_stall_cnt,
   output logic [CNT_W-1:0]         br_stall_cnt,
   output logic [CNT_W-1:0]         taken_cnt,
   output logic [CNT_W-1:0]         untaken_cnt,
   output logic [CNT_W-1:0]         total_cnt
);
   localparam int unsigned RW      = $clog2(NREG);
   localparam int unsigned PEN_MAX = NSRC * LD_PEN + BR_PEN;
   localparam int unsigned PEN_W   = $clog2(PEN_MAX + 1);
   localparam int unsigned IW      = ((BASE_W > PEN_W) ? BASE_W : PEN_W) + 1;

   if (NREG < 2)      begin : g_bad_nreg  $error("NREG must be at least 2");       end
   if (CNT_W < IW)    begin : g_bad_cntw  $error("CNT_W too narrow for one step"); end
   if (BASE_W < 1)    begin : g_bad_basew $error("BASE_W must be at least 1");     end

   logic is_load, is_br;
   logic [NSRC-1:0]    chk, hit;
   logic [NSRC*RW-1:0] srcs;
   logic [IW-1:0]      ld_inc, br_inc, tot_inc;

   assign is_load = (ins_cls == CLS_LOAD);
   assign is_br   = (ins_cls == CLS_BRANCH);
   assign srcs    = {src_b, src_a};
   assign chk[0]  = ins_vld & src_a_vld & ~is_load;
   assign chk[1]  = ins_vld & src_b_vld & ~is_load & ~is_br;

   ldsa_scoreboard #(.NREG(NREG), .NS(NSRC)) u_sb (
      .clk     (clk),
      .rst     (rst),
      .adv     (ins_vld),
      .set_en  (is_load),
      .set_idx (ld_dst),
      .src_idx (srcs),
      .src_chk (chk),
      .hit     (hit)
   );

   always_comb begin
      ld_inc = '0;
      for (int i = 0; i < NSRC; i++)
         if (hit[i]) ld_inc = ld_inc + IW'(LD_PEN);
   end

   assign br_inc  = (is_br && taken) ? IW'(BR_PEN) : '0;
   assign tot_inc = IW'(base_cyc) + ld_inc + br_inc;

   logic [IW-1:0]    inc_v [NCTR];
   logic [NCTR-1:0]  en_v;
   logic [CNT_W-1:0] q_v   [NCTR];

   assign inc_v[C_LD]  = ld_inc;
   assign inc_v[C_BR]  = br_inc;
   assign inc_v[C_TK]  = IW'(1);
   assign inc_v[C_UT]  = IW'(1);
   assign inc_v[C_TOT] = tot_inc;
   assign en_v[C_LD]   = ins_vld;
   assign en_v[C_BR]   = ins_vld;
   assign en_v[C_TK]   = ins_vld & is_br & taken;
   assign en_v[C_UT]   = ins_vld & is_br & ~taken;
   assign en_v[C_TOT]  = ins_vld & grp_last;

   for (genvar k = 0; k < NCTR; k++) begin : g_ctr
      ldsa_satctr #(.W(CNT_W), .IW(IW)) u_ctr (
         .clk (clk),
         .rst (rst),
         .en  (en_v[k]),
         .inc (inc_v[k]),
         .q   (q_v[k])
      );
   end

   assign ld_stall_cnt = q_v[C_LD];
   assign br_stall_cnt = q_v[C_BR];
   assign taken_cnt    = q_v[C_TK];
   assign untaken_cnt  = q_v[C_UT];
   assign total_cnt    = q_v[C_TOT];
endmodule

// File: rtl/ldsa_stall_acct_chk.sv
module ldsa_stall_acct_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             ins_vld,
   input logic [2:0]       ins_cls,
   input logic             taken,
   input logic             grp_last,
   input logic [CNT_W-1:0] ld_stall_cnt,
   input logic [CNT_W-1:0] br_stall_cnt,
   input logic [CNT_W-1:0] taken_cnt,
   input logic [CNT_W-1:0] untaken_cnt,
   input logic [CNT_W-1:0] total_cnt
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (ld_stall_cnt == '0 && br_stall_cnt == '0 && taken_cnt == '0
               && untaken_cnt == '0 && total_cnt == '0));

   assert_single_use_R4: assert property (@(posedge clk) disable iff (rst)
      (ins_vld && ins_cls != 3'd4) ##1 ins_vld |=> $stable(ld_stall_cnt));

   assert_taken_step_R5: assert property (@(posedge clk) disable iff (rst)
      (ins_vld && ins_cls == 3'd3 && taken && taken_cnt != MAXV)
      |=> taken_cnt == $past(taken_cnt) + 1'b1);

   assert_untaken_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      (ins_vld && ins_cls == 3'd3 && !taken)
      |=> ($stable(br_stall_cnt) && $stable(taken_cnt)));

   assert_load_no_stall_R8: assert property (@(posedge clk) disable iff (rst)
      (ins_vld && ins_cls == 3'd4) |=> $stable(ld_stall_cnt));

   assert_total_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (ins_vld && !grp_last) |=> $stable(total_cnt));

   assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
      (total_cnt == MAXV) |=> (total_cnt == MAXV));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !ins_vld |=> ($stable(ld_stall_cnt) && $stable(br_stall_cnt) && $stable(taken_cnt)
                    && $stable(untaken_cnt) && $stable(total_cnt)));
endmodule

bind ldsa_stall_acct ldsa_stall_acct_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .ins_vld      (ins_vld),
   .ins_cls      (ins_cls),
   .taken        (taken),
   .grp_last     (grp_last),
   .ld_stall_cnt (ld_stall_cnt),
   .br_stall_cnt (br_stall_cnt),
   .taken_cnt    (taken_cnt),
   .untaken_cnt  (untaken_cnt),
   .total_cnt    (total_cnt)
);

// File: tb/ldsa_stall_acct_bench.sv
module ldsa_stall_acct_bench;
   localparam int unsigned NREG = 8;
   localparam int unsigned CW   = 12;
   localparam int unsigned MAXV = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ins_vld = 1'b0, src_a_vld = 1'b0, src_b_vld = 1'b0, taken = 1'b0, grp_last = 1'b0;
   logic [2:0] ins_cls = '0, src_a = '0, src_b = '0, ld_dst = '0;
   logic [3:0] base_cyc = '0;
   logic [CW-1:0] ld_stall_cnt, br_stall_cnt, taken_cnt, untaken_cnt, total_cnt;

   always #4 clk = ~clk;

   ldsa_stall_acct #(.NREG(NREG), .CNT_W(CW), .BASE_W(4)) u_ldsa_stall_acct (
      .clk(clk), .rst(rst), .ins_vld(ins_vld), .ins_cls(ins_cls),
      .src_a(src_a), .src_a_vld(src_a_vld), .src_b(src_b), .src_b_vld(src_b_vld),
      .ld_dst(ld_dst), .taken(taken), .base_cyc(base_cyc), .grp_last(grp_last),
      .ld_stall_cnt(ld_stall_cnt), .br_stall_cnt(br_stall_cnt), .taken_cnt(taken_cnt),
      .untaken_cnt(untaken_cnt), .total_cnt(total_cnt));

   int n_chk = 0, n_fail = 0, cyc = 0;
   int unsigned m_ld, m_br, m_tk, m_ut, m_tot;
   logic [NREG-1:0] m_mask;

   function automatic int unsigned sat(int unsigned a, int unsigned b);
      return (a + b > MAXV) ? MAXV : a + b;
   endfunction

   task automatic check(string tag, string nm, int unsigned act, int unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check(tag, "ld_stall_cnt", ld_stall_cnt, m_ld);
      check(tag, "br_stall_cnt", br_stall_cnt, m_br);
      check(tag, "taken_cnt",    taken_cnt,    m_tk);
      check(tag, "untaken_cnt",  untaken_cnt,  m_ut);
      check(tag, "total_cnt",    total_cnt,    m_tot);
   endtask

   task automatic do_reset(string tag);
      rst = 1'b1; ins_vld = 1'b0;
      @(posedge clk); #1;
      rst = 1'b0;
      m_ld = 0; m_br = 0; m_tk = 0; m_ut = 0; m_tot = 0; m_mask = '0;
      check_all(tag);
   endtask

   task automatic idle(int n, string tag);
      ins_vld = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         check_all(tag);
      end
   endtask

   task automatic ins(input int c, input int a, input bit va, input int b, input bit vb,
                      input int d, input bit tk, input int base, input bit last, input string tag);
      int unsigned hits, brp;
      ins_vld = 1'b1; ins_cls = 3'(c); src_a = 3'(a); src_a_vld = va;
      src_b = 3'(b); src_b_vld = vb; ld_dst = 3'(d); taken = tk;
      base_cyc = 4'(base); grp_last = last;
      hits = 0;
      if (c != 4 && va && m_mask[a]) hits++;
      if (c != 4 && c != 3 && vb && m_mask[b]) hits++;
      brp = (c == 3 && tk) ? 2 : 0;
      m_ld = sat(m_ld, 2 * hits);
      m_br = sat(m_br, brp);
      if (c == 3 && tk)  m_tk = sat(m_tk, 1);
      if (c == 3 && !tk) m_ut = sat(m_ut, 1);
      if (last) m_tot = sat(m_tot, base + 2 * hits + brp);
      m_mask = '0;
      if (c == 4) m_mask[d] = 1'b1;
      @(posedge clk); #1;
      ins_vld = 1'b0;
      check_all(tag);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      m_mask = '0;
      #2;
      do_reset("R1");
      idle(3, "R11");

      // R2/R3/R7/R8 sweep: load to d, then consumer of every class and source pattern
      for (int d = 0; d < 8; d++)
         for (int c = 0; c < 8; c++)
            for (int a = 0; a < 8; a++)
               for (int vv = 0; vv < 4; vv++) begin
                  ins(4, (a + 1) % 8, 1'b1, a, 1'b1, d, 1'b0, 1, 1'b1, "R8");
                  ins(c, a, vv[0], (a + d + vv) % 8, vv[1], 0, 1'(a % 2),
                      (a * 3 + c) % 16, vv != 2, "R2");
               end

      do_reset("R1");
      // R2: both sources on the pending register count twice
      ins(4, 0, 0, 0, 0, 5, 0, 1, 1, "R8");
      ins(1, 5, 1, 5, 1, 0, 0, 1, 1, "R2");
      check("R2", "double hit", ld_stall_cnt, 4);
      // R3: invalid sources on the pending register
      ins(4, 0, 0, 0, 0, 5, 0, 1, 1, "R8");
      ins(0, 5, 0, 5, 0, 0, 0, 1, 1, "R3");
      check("R3", "no stall when invalid", ld_stall_cnt, 4);
      // R4: second instruction after load does not stall
      ins(4, 0, 0, 0, 0, 3, 0, 1, 1, "R8");
      ins(0, 0, 0, 0, 0, 0, 0, 1, 1, "R4");
      ins(0, 3, 1, 3, 1, 0, 0, 1, 1, "R4");
      check("R4", "consumed mark", ld_stall_cnt, 4);
      // R4: idle gap keeps the mark
      ins(4, 0, 0, 0, 0, 6, 0, 1, 1, "R8");
      idle(4, "R11");
      ins(5, 6, 1, 0, 0, 0, 0, 1, 1, "R4");
      check("R4", "mark across idle", ld_stall_cnt, 6);
      // R7: branch ignores src_b
      ins(4, 0, 0, 0, 0, 2, 0, 1, 1, "R8");
      ins(3, 1, 1, 2, 1, 0, 1, 3, 1, "R7");
      check("R7", "branch src_b ignored", ld_stall_cnt, 6);
      // R8: load reading pending register
      ins(4, 0, 0, 0, 0, 7, 0, 1, 1, "R8");
      ins(4, 7, 1, 7, 1, 7, 0, 1, 1, "R8");
      check("R8", "load no stall", ld_stall_cnt, 6);
      // R5/R6
      ins(3, 0, 0, 0, 0, 0, 1, 2, 1, "R5");
      ins(3, 0, 0, 0, 0, 0, 0, 2, 1, "R6");
      // R9: no group-last
      ins(3, 0, 0, 0, 0, 0, 1, 9, 0, "R9");

      // R10: drive every counter to saturation
      for (int i = 0; i < 2100; i++) begin
         ins(4, 0, 0, 0, 0, i % 8, 0, 15, 1, "R10");
         ins(2, i % 8, 1, i % 8, 1, 0, 0, 15, 1, "R10");
         ins(3, 0, 0, 0, 0, 0, 1, 15, 1, "R10");
         ins(3, 0, 0, 0, 0, 0, 1, 15, 1, "R10");
         ins(3, 0, 0, 0, 0, 0, 0, 15, 1, "R10");
         ins(3, 0, 0, 0, 0, 0, 0, 15, 1, "R10");
      end
      check("R10", "ld saturated", ld_stall_cnt, MAXV);
      check("R10", "taken saturated", taken_cnt, MAXV);
      check("R10", "untaken saturated", untaken_cnt, MAXV);
      check("R10", "total saturated", total_cnt, MAXV);
      idle(2, "R11");
      do_reset("R1");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule